// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the digital serial port of a sampling converter that runs in externally clocked mode. It cycles through three phases under an active-low chip select: converting, sleeping once a result is ready, and shifting a 24-bit result frame out while it shifts a channel-select word in. One output pin does double duty. While a conversion runs it shows a busy/ready flag, and during readout it carries the frame data. The output is released (enable low) whenever chip select is high, so the line can be shared with other devices.

A converter core (a stub here) gets a one-cycle start pulse from the port. It answers some time later with a one-cycle done pulse and a 24-bit result word. The port loads the word on that pulse. It cannot stall the core: there is no back-pressure on the result path. A word that arrives is captured and replaces the previous one, and the core is only ever started by the port itself. The serial pins (chip select, serial clock, serial data in) are asynchronous to the system clock. They pass through two-flop synchronizers, and the serial clock must stay in each phase for at least four system clocks. A new conversion starts when a frame is fully read, or when chip select rises after at least one rising serial-clock edge. The captured channel word takes effect only when a frame completes.

Top module: `csp_port`

## Requirements
- R1: `sdo_oe` is 0 while the synchronized chip select is high and 1 while it is low; `sdo` reads 0 whenever `sdo_oe` is 0.
- R2: While a conversion is in progress and chip select is low, `sdo` is 1 (busy).
- R3: A conversion that finishes with chip select high leaves the port asleep: no start pulse is issued, and the result is held until chip select falls. At that point `sdo` becomes 0 (ready) and readout begins.
- R4: The frame is 24 bits long and sent MSB first. Bit 23 is always sent as 0. Bits 22..0 are bits 22..0 of the captured result word. The first bit is present as soon as readout begins, and each later bit appears after a falling serial-clock edge.
- R5: The 24th rising serial-clock edge of a frame causes exactly one conversion start.
- R6: Chip select rising after 1 to 23 rising serial-clock edges abandons the frame and causes exactly one conversion start.
- R7: Chip select rising during readout before any rising serial-clock edge returns the port to sleep without a start, and the same frame can be read again in full.
- R8: `sdi` is sampled on rising serial-clock edges. The first 8 bits of a frame, MSB first, become `chan_sel` once the 24th edge is taken. `chan_sel` resets to 0.
- R9: An abandoned frame leaves `chan_sel` unchanged.
- R10: `conv_start` is a pulse exactly one system clock wide, and one is issued after reset.
- R11: If the done pulse arrives while chip select is low, `sdo` falls from 1 to 0 and readout begins without chip select being toggled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sck | input | 1 | Serial clock from the host, asynchronous |
| sdi | input | 1 | Serial data in (channel word) |
| sdo | output | 1 | Serial data out / busy-ready flag |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| conv_start | output | 1 | One-cycle conversion start to the core |
| conv_done | input | 1 | One-cycle conversion done from the core |
| conv_word | input | 24 | Result word, valid with `conv_done` |
| chan_sel | output | 8 | Channel selection last committed by a full frame |

## Verification
If the phase register is wrong, the error shows on `sdo` within one serial-clock phase. Examples are a busy flag where ready is expected, a premature ready flag, or a missing start pulse, which leaves the port stuck asleep and shows up as no fresh frame on the next read. If the bit counter or shift register is off, the data pin diverges from the expected frame at the first falling edge after the fault. A wrong channel capture only becomes visible on `chan_sel` after the next completed frame. For that reason the sweep checks `chan_sel` after every one of 256 frames, and it checks again after every abort length from 1 to 23.

// File: rtl/csp_pkg.sv
package csp_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_DOUT  = 2'd3
  } csp_state_e;
endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= rst_val;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/csp_frame.sv
module csp_frame #(
  parameter int FRAME = 24,
  parameter int CH_W  = 8,
  localparam int CNT_W = $clog2(FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [FRAME-1:0] word,
  input  logic             active,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             sdi,
  input  logic             commit,
  output logic             sdo_bit,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [CH_W-1:0]  chan_sel
);
  localparam logic [CNT_W-1:0] CH_LIM = CNT_W'(CH_W);
  localparam logic [CNT_W-1:0] F_LIM  = CNT_W'(FRAME);

  logic [FRAME-1:0] shreg;
  logic [CH_W-1:0]  cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      cap     <= '0;
    end else if (load) begin
      shreg   <= {1'b0, word[FRAME-2:0]};
      bit_cnt <= '0;
      cap     <= '0;
    end else if (active) begin
      if (sck_rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt < CH_LIM) cap <= {cap[CH_W-2:0], sdi};
      end else if (sck_fall && bit_cnt != '0) begin
        shreg <= {shreg[FRAME-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chan_sel <= '0;
    else if (commit) chan_sel <= cap;
  end

  assign sdo_bit = shreg[FRAME-1];

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= F_LIM);
  // R9
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(chan_sel));
endmodule

// File: rtl/csp_port.sv
module csp_port #(
  parameter int FRAME = 24,
  parameter int CH_W  = 8,
  localparam int CNT_W = $clog2(FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [FRAME-1:0] conv_word,
  output logic [CH_W-1:0]  chan_sel
);
  import csp_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME - 1);

  logic [2:0] pins_s;
  logic       cs_s, sck_s, sdi_s, sck_q;
  logic       sck_rise, sck_fall, active, commit, sdo_bit;
  logic [CNT_W-1:0] bit_cnt;
  csp_state_e state, state_nx;

  csp_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_val(3'b100),
    .d({cs_n, sck, sdi}), .q(pins_s)
  );
  assign {cs_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= 1'b0;
    else sck_q <= sck_s;
  end
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  assign active = (state == ST_DOUT) && !cs_s;
  assign commit = active && sck_rise && (bit_cnt == LAST);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_START: state_nx = ST_CONV;
      ST_CONV:  if (conv_done) state_nx = cs_s ? ST_SLEEP : ST_DOUT;
      ST_SLEEP: if (!cs_s) state_nx = ST_DOUT;
      ST_DOUT: begin
        if (cs_s) state_nx = (bit_cnt == '0) ? ST_SLEEP : ST_START;
        else if (commit) state_nx = ST_START;
      end
      default: state_nx = ST_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_START;
    else state <= state_nx;
  end

  csp_frame #(.FRAME(FRAME), .CH_W(CH_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .load(conv_done && state == ST_CONV), .word(conv_word),
    .active(active), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi(sdi_s), .commit(commit),
    .sdo_bit(sdo_bit), .bit_cnt(bit_cnt), .chan_sel(chan_sel)
  );

  assign conv_start = (state == ST_START);
  assign sdo_oe     = ~cs_s;

  always_comb begin
    if (cs_s) sdo = 1'b0;
    else if (state == ST_DOUT) sdo = sdo_bit;
    else if (state == ST_SLEEP) sdo = 1'b0;
    else sdo = 1'b1;
  end

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R2
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && (state == ST_START || state == ST_CONV)) |-> (sdo_oe && sdo));
  // R6
  abort_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOUT && cs_s && bit_cnt != '0) |=> conv_start);
  // R7
  early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOUT && cs_s && bit_cnt == '0) |=> (state == ST_SLEEP && !conv_start));
  // R3
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |-> !conv_start);
endmodule

// File: tb/tb_csp_port.sv
module tb_csp_port;
  localparam int HALF = 6;
  localparam int LAT  = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, conv_start, conv_done;
  logic [23:0] conv_word, res_q;
  logic [7:0] chan_sel;
  int n_checks = 0, n_fail = 0;
  int starts = 0, idx = 0, lat = 0;
  logic busy = 1'b0;

  always #5 clk = ~clk;

  csp_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .conv_start(conv_start),
    .conv_done(conv_done), .conv_word(conv_word), .chan_sel(chan_sel)
  );

  // converter stub
  always @(posedge clk) begin
    if (!rst_n) begin
      conv_done <= 1'b0; conv_word <= '0; res_q <= '0; lat <= 0; busy <= 1'b0;
    end else begin
      conv_done <= 1'b0;
      if (conv_start) begin
        starts <= starts + 1; lat <= LAT; busy <= 1'b1;
      end else if (lat != 0) begin
        lat <= lat - 1;
        if (lat == 1) begin
          conv_done <= 1'b1;
          conv_word <= (24'(idx) * 24'h01F3A7) ^ 24'hD5A55A;
          res_q     <= (24'(idx) * 24'h01F3A7) ^ 24'hD5A55A;
          idx <= idx + 1; busy <= 1'b0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (busy || lat != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic clock_bits(input int n, input logic [7:0] ch, input logic [23:0] exp_fr);
    for (int b = 0; b < n; b++) begin
      sdi = (b < 8) ? ch[7-b] : 1'b0;
      repeat (HALF) @(negedge clk);
      chk(sdo === exp_fr[23-b] && sdo_oe === 1'b1, "R4 frame bit", sdo, exp_fr[23-b]);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic full_read(input logic [7:0] ch);
    logic [23:0] fr;
    int s0;
    fr = {1'b0, res_q[22:0]};
    s0 = starts;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(sdo === 1'b0 && sdo_oe === 1'b1, "R3 ready flag", sdo, 0);
    clock_bits(24, ch, fr);
    repeat (HALF) @(negedge clk);
    chk(starts == s0 + 1, "R5 one start after frame", starts - s0, 1);
    chk(chan_sel == ch, "R8 channel committed", chan_sel, ch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int s0;
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    chk(sdo_oe === 1'b0 && sdo === 1'b0, "R1 reset released line", sdo_oe, 0);
    chk(chan_sel == 8'h00, "R8 reset channel", chan_sel, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(starts == 1, "R10 start after reset", starts, 1);

    // R3: sleep with cs high, no spurious start
    wait_ready();
    s0 = starts;
    repeat (30) @(negedge clk);
    chk(starts == s0, "R3 no start while asleep", starts, s0);
    chk(sdo_oe === 1'b0, "R1 released while cs high", sdo_oe, 0);

    // R8/R4/R5 sweep over every channel value
    for (int c = 0; c < 256; c++) begin
      wait_ready();
      chk(sdo_oe === 1'b0, "R1 released between frames", sdo_oe, 0);
      full_read(8'(c));
      cs_n = 1'b1;
    end

    // R7: release before first edge, then re-read same frame
    wait_ready();
    s0 = starts;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(starts == s0, "R7 no start on early release", starts, s0);
    chk(sdo_oe === 1'b0, "R1 released after early release", sdo_oe, 0);
    full_read(8'h3C);
    cs_n = 1'b1;

    // R6/R9: abort after k edges
    prev = chan_sel;
    for (int k = 1; k < 24; k++) begin
      wait_ready();
      s0 = starts;
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      clock_bits(k, ~prev, {1'b0, res_q[22:0]});
      repeat (2) @(negedge clk);
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
      chk(starts == s0 + 1, "R6 abort starts conversion", starts - s0, 1);
      chk(chan_sel == prev, "R9 channel kept on abort", chan_sel, prev);
    end

    // R2/R11: keep cs low through conversion
    wait_ready();
    full_read(8'hA7);
    repeat (4) @(negedge clk);
    chk(sdo === 1'b1 && sdo_oe === 1'b1, "R2 busy while converting", sdo, 1);
    wait_ready();
    chk(sdo === 1'b0, "R11 ready without cs toggle", sdo, 0);
    s0 = starts;
    clock_bits(24, 8'h5E, {1'b0, res_q[22:0]});
    repeat (HALF) @(negedge clk);
    chk(starts == s0 + 1, "R5 start after back-to-back frame", starts - s0, 1);
    chk(chan_sel == 8'h5E, "R8 channel back-to-back", chan_sel, 8'h5E);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule